// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block lights a row of common-segment seven-segment digits from a small set of pins. It takes one hexadecimal nibble, one decimal-point bit and one blank bit for each digit. It then steps through the digits one slot at a time. A single shared set of eight segment lines carries the pattern of the digit whose select line is active. Every output is active low: a low level lights a segment or enables a digit.

A prescaler divides the system clock into scan slots. With the default 50 MHz clock and a 1 kHz slot rate, each digit holds the display for 1 ms, and four digits refresh at about 250 Hz. The first few cycles of every slot are dark, with all selects high. This stops the previous digit's pattern from showing faintly on the next digit. The glyphs are fixed hexadecimal shapes, and b and d are drawn in lowercase.

Top module: `seg_scan_top`

## Requirements
- R1: Segment output `seg_n` is active low, with bit 7 = a, 6 = b, 5 = c, 4 = d, 3 = e, 2 = f, 1 = g and 0 = DP. The glyph bits `seg_n[7:1]` (a..g) for digits 0–9 are 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000 and 0000100.
- R2: The glyph bits for the hex letters are A = 0001000, b = 1100000, C = 0110001, d = 1000010, E = 0110000 and F = 0111000.
- R3: At most one bit of `an_n` is low in any cycle. A low `an_n[i]` enables digit i, which shows nibble `digit_val[4i+3:4i]`. Digit 3 is the left-most digit and digit 0 the right-most.
- R4: Digits are scanned in the order 0, 1, 2, …, NUM_DIGITS-1 and then wrap back to 0. Each slot lasts SLOT_CYCLES = CLK_HZ/SCAN_HZ clock cycles.
- R5: For the first BLANK_CYCLES cycles of each slot, all anodes and all segments are high. For the rest of the slot, the slot's digit is lit.
- R6: While a digit is lit, `seg_n[0]` is low exactly when that digit's `dp_in` bit is 1.
- R7: While `blank_in[i]` is 1, `an_n[i]` stays high for digit i's whole slot and the segments stay high. The other digits keep their normal slots.
- R8: Synchronous reset drives every output high on the next edge and restarts the scan at digit 0. The first lit output appears on the (BLANK_CYCLES+1)-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_val | input | 4*NUM_DIGITS | Hex nibble per digit, digit i at bits 4i+3:4i |
| dp_in | input | NUM_DIGITS | Decimal point request per digit, 1 lights DP |
| blank_in | input | NUM_DIGITS | Blank mask per digit, 1 keeps the digit dark |
| seg_n | output | 8 | Shared segments a..g, DP, active low |
| an_n | output | NUM_DIGITS | Per-digit anode selects, active low |

## Verification
The bench builds the block with CLK_HZ = 1000 and SCAN_HZ = 50, which gives 20-cycle slots, and with BLANK_CYCLES = 4 and four digits. The default 50,000-cycle slot is shrunk this way so that each full scan frame takes 80 cycles. Within a few hundred cycles the bench can therefore show all sixteen glyphs, each decimal-point pattern, partial and full blank masks, the dark gap of every slot, and a reset in the middle of a slot. The slot count is not a power of two, so the counter variant that resets on compare is the one exercised.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
   localparam int NIB_W = 4;
   localparam int SEG_W = 8;
   typedef logic [6:0] glyph_t;   // a..g, active low, a in the MSB
endpackage

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
   import seg_scan_pkg::*;
(
   input  logic [NIB_W-1:0] nib,
   output glyph_t           glyph_n
);
   always_comb begin
      unique case (nib)
         4'h0: glyph_n = 7'b0000001;
         4'h1: glyph_n = 7'b1001111;
         4'h2: glyph_n = 7'b0010010;
         4'h3: glyph_n = 7'b0000110;
         4'h4: glyph_n = 7'b1001100;
         4'h5: glyph_n = 7'b0100100;
         4'h6: glyph_n = 7'b0100000;
         4'h7: glyph_n = 7'b0001111;
         4'h8: glyph_n = 7'b0000000;
         4'h9: glyph_n = 7'b0000100;
         4'hA: glyph_n = 7'b0001000;
         4'hB: glyph_n = 7'b1100000;
         4'hC: glyph_n = 7'b0110001;
         4'hD: glyph_n = 7'b1000010;
         4'hE: glyph_n = 7'b0110000;
         default: glyph_n = 7'b0111000;
      endcase
   end
endmodule

// File: rtl/seg_prescaler.sv
module seg_prescaler #(
   parameter int SLOT_CYCLES = 50000,
   localparam int CNT_W = $clog2(SLOT_CYCLES)
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             slot_last
);
   localparam bit IS_POW2 = (SLOT_CYCLES & (SLOT_CYCLES - 1)) == 0;

   assign slot_last = (cnt == CNT_W'(SLOT_CYCLES - 1));

   generate
      if (IS_POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + CNT_W'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst || slot_last) cnt <= '0;
            else                  cnt <= cnt + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/seg_digit_seq.sv
module seg_digit_seq #(
   parameter int NUM_DIGITS = 4,
   localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             advance,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (advance)
         idx <= (idx == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx + IDX_W'(1);
   end
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
   import seg_scan_pkg::*;
#(
   parameter int NUM_DIGITS   = 4,
   parameter int CLK_HZ       = 50_000_000,
   parameter int SCAN_HZ      = 1000,
   parameter int BLANK_CYCLES = 250
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NIB_W*NUM_DIGITS-1:0] digit_val,
   input  logic [NUM_DIGITS-1:0]       dp_in,
   input  logic [NUM_DIGITS-1:0]       blank_in,
   output logic [SEG_W-1:0]            seg_n,
   output logic [NUM_DIGITS-1:0]       an_n
);
   localparam int SLOT_CYCLES = CLK_HZ / SCAN_HZ;
   localparam int CNT_W       = $clog2(SLOT_CYCLES);
   localparam int IDX_W       = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

   generate
      if (SLOT_CYCLES <= BLANK_CYCLES) begin : g_bad_slot
         $error("seg_scan_top: slot of %0d cycles leaves no lit time", SLOT_CYCLES);
      end
      if (BLANK_CYCLES < 1) begin : g_bad_blank
         $error("seg_scan_top: BLANK_CYCLES must be at least 1");
      end
      if (NUM_DIGITS < 1) begin : g_bad_digits
         $error("seg_scan_top: NUM_DIGITS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             slot_last;
   logic [IDX_W-1:0] idx;

   seg_prescaler #(.SLOT_CYCLES(SLOT_CYCLES)) u_pre (
      .clk(clk), .rst(rst), .cnt(cnt), .slot_last(slot_last)
   );

   seg_digit_seq #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
      .clk(clk), .rst(rst), .advance(slot_last), .idx(idx)
   );

   // digit data split per position
   logic [NIB_W-1:0] nib_arr [NUM_DIGITS];
   generate
      for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_split
         assign nib_arr[g] = digit_val[g*NIB_W +: NIB_W];
      end
   endgenerate

   logic [NIB_W-1:0] cur_nib;
   logic             cur_dp;
   logic             cur_blank;
   logic             show;
   glyph_t           glyph_n;

   assign cur_nib   = nib_arr[idx];
   assign cur_dp    = dp_in[idx];
   assign cur_blank = blank_in[idx];
   assign show      = (cnt >= CNT_W'(BLANK_CYCLES)) && !cur_blank;

   seg_glyph_rom u_rom (.nib(cur_nib), .glyph_n(glyph_n));

   logic [NUM_DIGITS-1:0] an_next;
   generate
      for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_an
         assign an_next[g] = !(show && (idx == IDX_W'(g)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         an_n  <= '1;
         seg_n <= '1;
      end else begin
         an_n  <= an_next;
         seg_n <= show ? {glyph_n, ~cur_dp} : '1;
      end
   end
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
   parameter int NUM_DIGITS   = 4,
   parameter int BLANK_CYCLES = 250
) (
   input logic                  clk,
   input logic                  rst,
   input logic [NUM_DIGITS-1:0] blank_in,
   input logic [NUM_DIGITS-1:0] an_n,
   input logic [7:0]            seg_n
);
   localparam int DC_W = $clog2(BLANK_CYCLES + 1);

   logic [DC_W-1:0] dark_cnt;
   always_ff @(posedge clk) begin
      if (rst)
         dark_cnt <= '0;
      else if (an_n == '1)
         dark_cnt <= (dark_cnt == DC_W'(BLANK_CYCLES)) ? dark_cnt : dark_cnt + DC_W'(1);
      else
         dark_cnt <= '0;
   end

   assert_one_anode_R3: assert property (@(posedge clk) disable iff (rst)
      $countones(~an_n) <= 1);

   assert_reset_dark_R8: assert property (@(posedge clk)
      rst |=> (an_n == '1 && seg_n == '1));

   assert_no_direct_swap_R5: assert property (@(posedge clk) disable iff (rst)
      (an_n != '1 && $past(an_n) != '1) |-> an_n == $past(an_n));

   assert_gap_length_R5: assert property (@(posedge clk) disable iff (rst)
      (an_n != '1 && $past(an_n) == '1) |-> dark_cnt >= DC_W'(BLANK_CYCLES));

   assert_dark_segs_R5: assert property (@(posedge clk) disable iff (rst)
      (an_n == '1) |-> seg_n == '1);

   generate
      for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_blk
         assert_blank_holds_R7: assert property (@(posedge clk) disable iff (rst)
            $past(blank_in[g]) |-> an_n[g]);
      end
   endgenerate
endmodule

bind seg_scan_top seg_scan_chk #(
   .NUM_DIGITS(NUM_DIGITS), .BLANK_CYCLES(BLANK_CYCLES)
) u_chk (
   .clk(clk), .rst(rst), .blank_in(blank_in), .an_n(an_n), .seg_n(seg_n)
);

// File: tb/tb_seg_scan_top.sv
module tb_seg_scan_top;
   localparam int ND    = 4;
   localparam int SLOT  = 20;
   localparam int BLANK = 4;
   localparam int FRAME = SLOT * ND;

   typedef struct {
      logic [ND-1:0] an;
      logic [7:0]    seg;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [15:0]   digit_val = '0;
   logic [ND-1:0] dp_in = '0;
   logic [ND-1:0] blank_in = '0;
   logic [7:0]    seg_n;
   logic [ND-1:0] an_n;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   item_t q[$];
   item_t cur;
   bit    have_cur = 1'b0;

   always #5 clk = ~clk;

   seg_scan_top #(.NUM_DIGITS(ND), .CLK_HZ(1000), .SCAN_HZ(50), .BLANK_CYCLES(BLANK)) dut (
      .clk(clk), .rst(rst), .digit_val(digit_val), .dp_in(dp_in),
      .blank_in(blank_in), .seg_n(seg_n), .an_n(an_n)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   function automatic logic [6:0] glyph(input logic [3:0] v);
      logic [6:0] t [16];
      t[0]  = 7'b0000001; t[1]  = 7'b1001111; t[2]  = 7'b0010010; t[3]  = 7'b0000110;
      t[4]  = 7'b1001100; t[5]  = 7'b0100100; t[6]  = 7'b0100000; t[7]  = 7'b0001111;
      t[8]  = 7'b0000000; t[9]  = 7'b0000100; t[10] = 7'b0001000; t[11] = 7'b1100000;
      t[12] = 7'b0110001; t[13] = 7'b1000010; t[14] = 7'b0110000; t[15] = 7'b0111000;
      return t[v];
   endfunction

   task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual an/seg=%h expected %h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // driver side: load inputs and push what the next frame must show
   task automatic push_frame(input logic [15:0] d, input logic [ND-1:0] dp,
                             input logic [ND-1:0] bl, input string tag);
      digit_val = d;
      dp_in     = dp;
      blank_in  = bl;
      for (int i = 0; i < ND; i++) begin
         item_t it;
         it.tag = tag;
         if (bl[i]) begin
            it.an  = '1;
            it.seg = 8'hFF;
         end else begin
            it.an  = ~(ND'(1) << i);
            it.seg = {glyph(d[i*4 +: 4]), ~dp[i]};
         end
         q.push_back(it);
      end
   endtask

   task automatic wait_frame_end();
      do @(negedge clk); while (cyc == 0 || ((cyc - 1) % FRAME) != FRAME - 1);
      #1;
   endtask

   // monitor: position in frame from cycles since reset release
   always @(negedge clk) begin
      if (!rst && cyc > 0) begin
         int p;
         int c;
         p = (cyc - 1) % FRAME;
         c = p % SLOT;
         if (c < BLANK) begin
            // R5 dark gap at slot start
            check(an_n == '1 && seg_n == 8'hFF, "R5", {an_n, seg_n}, {4'hF, 8'hFF});
         end else begin
            if (c == BLANK) begin
               if (q.size() == 0) begin
                  have_cur = 1'b0;
                  check(1'b0, "R4 queue empty", {an_n, seg_n}, 12'h0);
               end else begin
                  cur = q.pop_front();
                  have_cur = 1'b1;
               end
            end
            if (have_cur)
               check(an_n == cur.an && seg_n == cur.seg,
                     {cur.tag, " R3/R4"}, {an_n, seg_n}, {cur.an, cur.seg});
         end
      end
   end

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      push_frame(16'h3210, 4'b0000, 4'b0000, "R1");
      repeat (3) @(negedge clk);
      check(an_n == '1 && seg_n == 8'hFF, "R8 reset", {an_n, seg_n}, {4'hF, 8'hFF});
      rst = 1'b0;
      wait_frame_end(); push_frame(16'h7654, 4'b0101, 4'b0000, "R1 R6");
      wait_frame_end(); push_frame(16'hBA98, 4'b1010, 4'b0000, "R2 R6");
      wait_frame_end(); push_frame(16'hFEDC, 4'b1111, 4'b0000, "R2");
      wait_frame_end(); push_frame(16'h5A5A, 4'b0000, 4'b0110, "R7");
      wait_frame_end(); push_frame(16'h1234, 4'b1111, 4'b1111, "R7");
      wait_frame_end(); push_frame(16'h0F0F, 4'b0000, 4'b0000, "R1");
      // reset in the middle of digit 1's lit time
      repeat (30) @(negedge clk);
      #1 rst = 1'b1;
      @(negedge clk);
      check(an_n == '1 && seg_n == 8'hFF, "R8 mid-scan", {an_n, seg_n}, {4'hF, 8'hFF});
      q.delete();
      have_cur = 1'b0;
      push_frame(16'hC0DE, 4'b1000, 4'b0000, "R8");
      #1 rst = 1'b0;
      wait_frame_end(); push_frame(16'h9E1B, 4'b0001, 4'b0100, "R2 R7");
      wait_frame_end();
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R4 all slots shown", 12'(q.size()), 12'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule